// File: doc/BRIEF.md
# Interrupt Vector Table Fetch Unit

This unit turns an 8-bit interrupt type number into the entry address of its service routine. The vector table sits in byte-addressed memory. The entry for type `n` starts at byte `4*n`, which is always even. An entry holds two 16-bit words. The lower-addressed word is the routine's offset and the higher-addressed word is its segment base. The 256 entries fill bytes 0x00000 to 0x003FF. For type 255, for example, the offset word is at 0x003FC and the segment word at 0x003FE.

A type enters over a valid/ready handshake. The unit then makes two word reads over a simple synchronous memory port: the offset first, then the segment. It forms the 20-bit physical address `segment*16 + offset`, keeping only the low 20 bits. It pulses `done` for one cycle and presents the result. Types 5 to 31 are a reserved range. For those types a flag is raised together with `done`, and the fetch still runs to the end. Types 32 to 255 are free for user software and hardware interrupts.

Back-pressure rules:
- A request moves on the rising edge where `req_valid` and `req_ready` are both high.
- `req_ready` is high only while the unit is idle.
- While a fetch is in progress, a valid request is neither taken nor queued.
- On the memory side, `mem_rd` and `mem_addr` stay unchanged until the edge on which `mem_rdy` is sampled high.
- `mem_rdata` is captured on that same edge.

Top module: `ivt_fetch_unit`

## Requirements
- R1: After reset `req_ready` is 1, and `done` and `mem_rd` are 0.
- R2: On the cycle after a request is accepted, `mem_rd` is 1 and `mem_addr` equals 4×type, the offset word.
- R3: After the offset word is accepted, the next read is at 4×type+2, the segment word. Each fetch makes exactly two word reads.
- R4: While `mem_rd` is 1 and `mem_rdy` is 0, the next cycle keeps `mem_rd` at 1 with the same `mem_addr`.
- R5: With `done`, `phys_addr` equals (segment×16 + offset) modulo 2^20.
- R6: `done` is high for exactly one cycle, the cycle after the segment word is accepted. `offset_out` and `segment_out` then show the two words read.
- R7: With `done`, `reserved` is 1 exactly when the type is in 5..31. A reserved type still completes both reads and produces a result.
- R8: `req_ready` is 0 from acceptance until the cycle after `done`. A `req_valid` held during that time starts no new fetch and does not change the result.
- R9: Every read address is even and lies in 0x00000..0x003FF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle, request will be taken |
| req_type | input | 8 | Interrupt type number |
| mem_rd | output | 1 | Word read strobe |
| mem_addr | output | 20 | Byte address of the word read |
| mem_rdy | input | 1 | Read data valid this cycle |
| mem_rdata | input | 16 | Read data |
| done | output | 1 | One-cycle result pulse |
| phys_addr | output | 20 | Physical entry address |
| offset_out | output | 16 | Offset word fetched |
| segment_out | output | 16 | Segment word fetched |
| reserved | output | 1 | Type lies in the reserved range |

## Verification
The assertions assume the following about the memory:
- `mem_rdy` is only meaningful while `mem_rd` is high.
- Read data is valid in the same cycle as `mem_rdy`.
- The memory may stall for any number of cycles.

No property depends on `req_type` except at the accepting edge.

The bench memory meets these assumptions in the following way:
- It raises `mem_rdy` at random, and only while a read is pending.
- It returns the table word for the address on the port.
- It holds each request valid until it is accepted.
- While busy, it keeps `req_valid` high with another type, to exercise the ignore rule.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
  localparam int TYPE_W     = 8;
  localparam int WORD_W     = 16;
  localparam int ADDR_W     = 20;
  localparam int SEG_SHIFT  = 4;
  localparam int RSV_LO     = 5;
  localparam int RSV_HI     = 31;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_OFF  = 2'd1,
    ST_SEG  = 2'd2,
    ST_DONE = 2'd3
  } fetch_state_t;
endpackage

// File: rtl/ivt_seq.sv
module ivt_seq
  import ivt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic mem_rdy,
  output logic req_ready,
  output logic rd_en,
  output logic sel_seg,
  output logic ld_req,
  output logic ld_off,
  output logic ld_seg,
  output logic done
);
  fetch_state_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (req_valid) st_d = ST_OFF;
      ST_OFF:  if (mem_rdy)   st_d = ST_SEG;
      ST_SEG:  if (mem_rdy)   st_d = ST_DONE;
      default:                st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign req_ready = (st_q == ST_IDLE);
  assign rd_en     = (st_q == ST_OFF) || (st_q == ST_SEG);
  assign sel_seg   = (st_q == ST_SEG);
  assign ld_req    = req_ready && req_valid;
  assign ld_off    = (st_q == ST_OFF) && mem_rdy;
  assign ld_seg    = (st_q == ST_SEG) && mem_rdy;
  assign done      = (st_q == ST_DONE);

  // R6: the result pulse lasts one cycle
  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R8: no request is taken while a read is pending
  assert_busy_closed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> !req_ready);
  // R6: done follows the segment word by one cycle
  assert_done_after_seg_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ld_seg |=> done);
endmodule

// File: rtl/ivt_capture.sv
module ivt_capture
  import ivt_pkg::*;
#(
  parameter int TW = TYPE_W,
  parameter int WW = WORD_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_req,
  input  logic          ld_off,
  input  logic          ld_seg,
  input  logic [TW-1:0] type_in,
  input  logic [WW-1:0] word_in,
  output logic [TW-1:0] type_q,
  output logic [WW-1:0] off_q,
  output logic [WW-1:0] seg_q,
  output logic          rsv_q
);
  localparam logic [TW-1:0] LO = TW'(RSV_LO);
  localparam logic [TW-1:0] HI = TW'(RSV_HI);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      type_q <= '0;
      off_q  <= '0;
      seg_q  <= '0;
      rsv_q  <= 1'b0;
    end else begin
      if (ld_req) begin
        type_q <= type_in;
        rsv_q  <= (type_in >= LO) && (type_in <= HI);
      end
      if (ld_off) off_q <= word_in;
      if (ld_seg) seg_q <= word_in;
    end
  end
endmodule

// File: rtl/ivt_addr_gen.sv
module ivt_addr_gen
  import ivt_pkg::*;
#(
  parameter int                TW         = TYPE_W,
  parameter int                AW         = ADDR_W,
  parameter logic [AW-1:0]     TABLE_BASE = '0
) (
  input  logic [TW-1:0] type_q,
  input  logic          sel_seg,
  output logic [AW-1:0] addr
);
  localparam int PAD = AW - TW - 2;

  generate
    if (PAD > 0) begin : g_pad
      assign addr = TABLE_BASE + {{PAD{1'b0}}, type_q, sel_seg, 1'b0};
    end else begin : g_nopad
      assign addr = TABLE_BASE + AW'({type_q, sel_seg, 1'b0});
    end
  endgenerate
endmodule

// File: rtl/ivt_phys_calc.sv
module ivt_phys_calc
  import ivt_pkg::*;
#(
  parameter int WW = WORD_W,
  parameter int AW = ADDR_W,
  parameter int SH = SEG_SHIFT
) (
  input  logic [WW-1:0] seg,
  input  logic [WW-1:0] off,
  output logic [AW-1:0] phys
);
  localparam int SUM_W = WW + SH + 1;
  logic [SUM_W-1:0] sum;

  assign sum = {1'b0, seg, {SH{1'b0}}} + SUM_W'(off);

  generate
    if (AW <= SUM_W) begin : g_trunc
      assign phys = sum[AW-1:0];
    end else begin : g_ext
      assign phys = AW'(sum);
    end
  endgenerate
endmodule

// File: rtl/ivt_fetch_unit.sv
module ivt_fetch_unit
  import ivt_pkg::*;
#(
  parameter int                TW         = TYPE_W,
  parameter int                WW         = WORD_W,
  parameter int                AW         = ADDR_W,
  parameter logic [AW-1:0]     TABLE_BASE = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [TW-1:0] req_type,
  output logic          mem_rd,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_rdy,
  input  logic [WW-1:0] mem_rdata,
  output logic          done,
  output logic [AW-1:0] phys_addr,
  output logic [WW-1:0] offset_out,
  output logic [WW-1:0] segment_out,
  output logic          reserved
);
  localparam logic [AW-1:0] TABLE_SPAN = AW'((1 << TW) * 4);

  logic          sel_seg, ld_req, ld_off, ld_seg;
  logic [TW-1:0] type_q;

  ivt_seq u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .mem_rdy(mem_rdy),
    .req_ready(req_ready), .rd_en(mem_rd), .sel_seg(sel_seg),
    .ld_req(ld_req), .ld_off(ld_off), .ld_seg(ld_seg), .done(done)
  );

  ivt_capture #(.TW(TW), .WW(WW)) u_cap (
    .clk(clk), .rst_n(rst_n), .ld_req(ld_req), .ld_off(ld_off),
    .ld_seg(ld_seg), .type_in(req_type), .word_in(mem_rdata),
    .type_q(type_q), .off_q(offset_out), .seg_q(segment_out),
    .rsv_q(reserved)
  );

  ivt_addr_gen #(.TW(TW), .AW(AW), .TABLE_BASE(TABLE_BASE)) u_agen (
    .type_q(type_q), .sel_seg(sel_seg), .addr(mem_addr)
  );

  ivt_phys_calc #(.WW(WW), .AW(AW)) u_phys (
    .seg(segment_out), .off(offset_out), .phys(phys_addr)
  );

  // R2: first read targets the offset word of the accepted type
  assert_first_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=>
      (mem_rd && mem_addr == TABLE_BASE + (AW'($past(req_type)) << 2)));
  // R3: segment word follows the offset word
  assert_seg_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && mem_rdy && !mem_addr[1]) |=>
      (mem_rd && mem_addr == $past(mem_addr) + AW'(2)));
  // R4: a stalled read holds its strobe and address
  assert_rd_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && !mem_rdy) |=> (mem_rd && $stable(mem_addr)));
  // R9: reads stay even and inside the table
  assert_addr_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> (!mem_addr[0] && (mem_addr - TABLE_BASE) < TABLE_SPAN));
endmodule

// File: tb/tb_ivt_fetch_unit.sv
`timescale 1ns/1ps
module tb_ivt_fetch_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [7:0]  req_type = '0;
  logic        mem_rd;
  logic [19:0] mem_addr;
  logic        mem_rdy = 1'b0;
  logic [15:0] mem_rdata = '0;
  logic        done;
  logic [19:0] phys_addr;
  logic [15:0] offset_out, segment_out;
  logic        reserved;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;
  int stall_pct = 25;

  always #2.5 clk = ~clk;

  ivt_fetch_unit dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_type(req_type), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .mem_rdy(mem_rdy), .mem_rdata(mem_rdata), .done(done),
    .phys_addr(phys_addr), .offset_out(offset_out),
    .segment_out(segment_out), .reserved(reserved)
  );

  function automatic logic [15:0] off_of(input logic [7:0] t);
    return {~t, t} ^ 16'h1234;
  endfunction
  function automatic logic [15:0] seg_of(input logic [7:0] t);
    return {t, ~t};
  endfunction
  function automatic logic [15:0] word_at(input logic [19:0] a);
    if (a[19:10] != 0 || a[0]) return 16'hDEAD;
    return a[1] ? seg_of(a[9:2]) : off_of(a[9:2]);
  endfunction
  function automatic logic [19:0] phys_of(input logic [7:0] t);
    logic [20:0] s;
    s = {1'b0, seg_of(t), 4'h0} + {5'h0, off_of(t)};
    return s[19:0];
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic sample();
    @(negedge clk);
    #1;
  endtask

  // behavioural memory: answers only while a read is pending
  initial begin
    forever begin
      @(negedge clk);
      if (mem_rd && (($urandom % 100) >= stall_pct)) begin
        mem_rdy   = 1'b1;
        mem_rdata = word_at(mem_addr);
      end else begin
        mem_rdy   = 1'b0;
        mem_rdata = 16'hBAD0;
      end
    end
  end

  task automatic fetch(input logic [7:0] t, input bit spam, input logic [7:0] t2);
    logic [19:0] a0, a1, prev_addr;
    int hs;
    bit prev_wait, got;
    hs = 0; prev_wait = 0; got = 0; a0 = '0; a1 = '0; prev_addr = '0;
    check(req_ready === 1'b1, "R8 idle ready", 32'(req_ready), 1);
    req_type  = t;
    req_valid = 1'b1;
    sample();
    check(req_ready === 1'b0, "R8 busy after accept", 32'(req_ready), 0);
    req_valid = spam;
    req_type  = spam ? t2 : t;
    for (int c = 0; c < 200; c++) begin
      if (prev_wait)
        check(mem_rd === 1'b1 && mem_addr === prev_addr, "R4 stall hold",
              32'(mem_addr), 32'(prev_addr));
      if (done === 1'b1) begin got = 1; break; end
      check(req_ready === 1'b0, "R8 busy", 32'(req_ready), 0);
      if (mem_rd && mem_rdy) begin
        if (hs == 0) a0 = mem_addr; else a1 = mem_addr;
        hs++;
      end
      prev_wait = mem_rd && !mem_rdy;
      prev_addr = mem_addr;
      sample();
    end
    req_valid = 1'b0;
    check(got, "R6 done seen", 32'(got), 1);
    check(hs == 2, "R3 read count", 32'(hs), 2);
    check(a0 === {10'h0, t, 2'b00}, "R2 offset addr", 32'(a0), 32'({t, 2'b00}));
    check(a1 === {10'h0, t, 2'b10}, "R3 segment addr", 32'(a1), 32'({t, 2'b10}));
    check(a0[0] == 1'b0 && a1[19:10] == 0, "R9 addr range", 32'(a1), 32'({t, 2'b10}));
    check(phys_addr === phys_of(t), "R5 phys", 32'(phys_addr), 32'(phys_of(t)));
    check(offset_out === off_of(t), "R6 offset", 32'(offset_out), 32'(off_of(t)));
    check(segment_out === seg_of(t), "R6 segment", 32'(segment_out), 32'(seg_of(t)));
    check(reserved === (t >= 5 && t <= 31), "R7 reserved", 32'(reserved),
          32'(t >= 5 && t <= 31));
    sample();
    check(done === 1'b0, "R6 single pulse", 32'(done), 0);
    check(mem_rd === 1'b0, "R8 no extra fetch", 32'(mem_rd), 0);
    check(req_ready === 1'b1, "R8 ready again", 32'(req_ready), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hang expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20250611));
    repeat (3) sample();
    check(req_ready === 1'b1, "R1 ready", 32'(req_ready), 1);
    check(done === 1'b0, "R1 done", 32'(done), 0);
    check(mem_rd === 1'b0, "R1 rd", 32'(mem_rd), 0);
    rst_n = 1'b1;
    sample();
    check(req_ready === 1'b1 && done === 1'b0 && mem_rd === 1'b0, "R1 after reset",
          {29'h0, req_ready, done, mem_rd}, 32'h4);
    // directed corners: boundaries of the reserved range, first and last entry
    stall_pct = 0;
    fetch(8'd0, 0, 8'd0);
    fetch(8'd4, 0, 8'd0);
    fetch(8'd5, 0, 8'd0);
    fetch(8'd31, 0, 8'd0);
    fetch(8'd32, 0, 8'd0);
    fetch(8'd255, 1, 8'd7);
    // every type, with random stalls and random busy-time requests
    stall_pct = 40;
    for (int t = 0; t < 256; t++)
      fetch(8'(t), ($urandom % 2) == 1, 8'($urandom));
    // random types under heavy stalls
    stall_pct = 80;
    for (int i = 0; i < 60; i++)
      fetch(8'($urandom), 1, 8'($urandom));
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule